// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters into frames on a single asynchronous serial line. Each frame has one start bit and 7, 8 or 9 data bits sent least significant bit first. An optional even or odd parity bit follows, then one or two stop bits. The line rests high between frames. Software-visible configuration arrives as plain input pins: character width, parity mode, stop count, an 8-bit divider value, the choice of bit-clock source and the interrupt point.

A single holding register sits in front of the frame shifter. A write strobe fills it and clears the empty flag. When transmission is enabled and the holding register is full, its contents move into the shifter, and the empty flag rises in time for the next character to be written. Because of this, consecutive frames follow each other with no idle time. The bit timer divides either the system clock or a synchronized external clock by 16 × (n + 1). An interrupt pulse marks either the moment a character leaves the holding register or the end of its last stop bit.

Top module: `uart_tx_cfg`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `txd` is 1, `buf_empty` is 1 and `irq` is 0.
- R2: A frame is a 0 start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits at 1. `txd` is 1 whenever no frame is in progress.
- R3: `char_len` selects the data width: 2'b00 gives 7 bits, 2'b01 and 2'b11 give 8 bits, 2'b10 gives 9 bits. Data bits above the width are ignored.
- R4: `par_mode` 2'b01 adds an even parity bit, so the count of ones over data and parity is even. 2'b10 adds an odd parity bit. 2'b00 and 2'b11 add no parity bit.
- R5: `two_stop` 0 sends one stop bit and 1 sends two.
- R6: With `ext_clk_sel` at 0, every bit lasts exactly 16 × (`div_n` + 1) clock cycles.
- R7: With `ext_clk_sel` at 1, every bit after the start bit spans exactly 16 × (`div_n` + 1) rising edges of `ext_clk`.
- R8: After a clock edge with `wr_stb` high, `buf_empty` is 0. A frame starts only while `tx_en` is 1. `buf_empty` returns to 1 in the cycle the start bit appears.
- R9: If the next character is already waiting when the last stop bit ends, its start bit follows with no idle cycles.
- R10: With `irq_on_end` at 0, `irq` is high for exactly one cycle, and that is the first cycle of the start bit.
- R11: With `irq_on_end` at 1, `irq` is high for exactly one cycle, starting (total frame bits) × bit period cycles after the start bit began.
- R12: Format settings are captured when a frame starts. Changing them during a frame does not alter that frame.
- R13: A write while the holding register is full replaces the waiting character. Only the last one written is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Allows a new frame to start |
| ext_clk_sel | input | 1 | 0: bit timer counts system clocks; 1: counts external clock rises |
| ext_clk | input | 1 | External clock, asynchronous |
| char_len | input | 2 | Data width select |
| par_mode | input | 2 | Parity select |
| two_stop | input | 1 | Two stop bits when 1 |
| irq_on_end | input | 1 | Interrupt point: 0 frame start, 1 frame end |
| div_n | input | 8 | Bit timer divider value n |
| wr_stb | input | 1 | Holding register write strobe |
| wr_data | input | 9 | Character to write |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register empty |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situation to reach is the seam between frames. There, the end of the last stop bit, the reload of the shifter, the clearing of the bit timer and an end-of-frame interrupt can all fall on the same clock edge. The stimulus reaches it by writing the second character while the first is still on its start bit, so the holding register is already full when the stop bit ends. The bench then samples the line one bit period after the middle of that stop bit and expects the next start bit. A second hard case is writing twice while transmission is disabled, which shows whether the waiting character is replaced or a stale one leaks out.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = DATA_W + 3;

  localparam logic [1:0] LEN_7  = 2'b00;
  localparam logic [1:0] LEN_8  = 2'b01;
  localparam logic [1:0] LEN_9  = 2'b10;

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ext_sel,
  input  logic             ext_clk,
  input  logic [DIV_W-1:0] div_n,
  output logic             bit_tick
);
  localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);

  logic [2:0]       sync_q;
  logic             src_tick;
  logic             pre_wrap;
  logic [DIV_W-1:0] pre_q;
  logic [OVS_W-1:0] sub_q;

  // two-flop synchronizer plus one stage for rising-edge detection
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], ext_clk};
  end

  assign src_tick = ext_sel ? (sync_q[1] & ~sync_q[2]) : 1'b1;
  assign pre_wrap = (pre_q == div_n);
  assign bit_tick = src_tick & pre_wrap & (sub_q == OVS_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (src_tick) begin
      if (pre_wrap) begin
        pre_q <= '0;
        sub_q <= (sub_q == OVS_LAST) ? '0 : sub_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= wr | (full & ~take);
      if (wr) data <= wdata;
    end
  end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              bit_tick,
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        len_sel,
  input  logic [1:0]        par_sel,
  input  logic              two_stop,
  output logic              txd,
  output logic              busy,
  output logic              last
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   nbits;
  int                 nd;
  logic               par_on;
  logic               ones;

  always_comb begin
    case (len_sel)
      LEN_7:   nd = 7;
      LEN_9:   nd = 9;
      default: nd = 8;
    endcase
    par_on = (par_sel == PAR_EVEN) || (par_sel == PAR_ODD);
    ones   = 1'b0;
    frame  = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nd) begin
        frame[i] = data[i];
        ones     = ones ^ data[i];
      end
    end
    if (par_on) frame[nd] = (par_sel == PAR_ODD) ? ~ones : ones;
    nbits = CNT_W'(nd + (par_on ? 1 : 0) + (two_stop ? 2 : 1));
  end

  assign last = busy & bit_tick & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      txd   <= 1'b1;
      busy  <= 1'b0;
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (load) begin
      txd   <= 1'b0;
      busy  <= 1'b1;
      sh_q  <= frame;
      cnt_q <= nbits;
    end else if (busy && bit_tick) begin
      if (cnt_q == '0) begin
        txd  <= 1'b1;
        busy <= 1'b0;
      end else begin
        txd   <= sh_q[0];
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              ext_clk_sel,
  input  logic              ext_clk,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  input  logic              two_stop,
  input  logic              irq_on_end,
  input  logic [DIV_W-1:0]  div_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              buf_empty,
  output logic              irq
);
  logic              full;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  logic              last;
  logic              bit_tick;
  logic              load_go;

  assign load_go   = tx_en & full & (~busy | last);
  assign buf_empty = ~full;

  uart_tx_hold #(.W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr(wr_stb), .wdata(wr_data),
    .take(load_go), .full(full), .data(hold_data)
  );

  uart_tx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk(clk), .rst(rst), .clr(~busy | load_go), .ext_sel(ext_clk_sel),
    .ext_clk(ext_clk), .div_n(div_n), .bit_tick(bit_tick)
  );

  uart_tx_frame u_frame (
    .clk(clk), .rst(rst), .load(load_go), .bit_tick(bit_tick),
    .data(hold_data), .len_sel(char_len), .par_sel(par_mode),
    .two_stop(two_stop), .txd(txd), .busy(busy), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_on_end ? last : load_go;
  end
endmodule

// File: rtl/uart_tx_cfg_chk.sv
module uart_tx_cfg_chk (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic buf_empty,
  input logic irq,
  input logic wr_stb,
  input logic irq_on_end,
  input logic busy
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (txd && buf_empty && !irq));

  assert_idle_mark_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  assert_write_fills_R8: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !buf_empty);

  assert_empty_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (buf_empty && !wr_stb) |=> buf_empty);

  assert_irq_on_start_R10: assert property (@(posedge clk) disable iff (rst)
    (irq && !$past(irq_on_end)) |-> !txd);

  assert_irq_after_stop_R11: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(irq_on_end)) |-> $past(txd));

  assert_irq_single_R11: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

bind uart_tx_cfg uart_tx_cfg_chk u_chk (
  .clk(clk), .rst(rst), .txd(txd), .buf_empty(buf_empty), .irq(irq),
  .wr_stb(wr_stb), .irq_on_end(irq_on_end), .busy(busy)
);

// File: tb/uart_tx_cfg_tb.sv
`timescale 1ns/1ps
module uart_tx_cfg_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, tx_en = 1'b0, ext_clk_sel = 1'b0, ext_clk;
  logic [1:0] char_len = 2'b01, par_mode = 2'b00;
  logic two_stop = 1'b0, irq_on_end = 1'b0, wr_stb = 1'b0;
  logic [7:0] div_n = 8'd2;
  logic [8:0] wr_data = '0;
  logic txd, buf_empty, irq;

  int cyc = 0, n_chk = 0, n_bad = 0, P = 48, t_fall = 0;
  logic irq_at_fall, irq_next;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  initial begin
    ext_clk = 1'b0;
    #(CLK_PERIOD/4);
    forever #(2*CLK_PERIOD) ext_clk = ~ext_clk;
  end

  uart_tx_cfg u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .ext_clk_sel(ext_clk_sel), .ext_clk(ext_clk),
    .char_len(char_len), .par_mode(par_mode), .two_stop(two_stop),
    .irq_on_end(irq_on_end), .div_n(div_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .txd(txd), .buf_empty(buf_empty), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_frame(input logic [8:0] d, input logic [1:0] len,
                                   input logic [1:0] par, input logic two,
                                   output logic [12:0] f);
    int nd, idx;
    logic p;
    nd = (len == 2'b00) ? 7 : (len == 2'b10) ? 9 : 8;
    f = '1; f[0] = 1'b0; p = 1'b0;
    for (int i = 0; i < nd; i++) begin f[1+i] = d[i]; p ^= d[i]; end
    idx = 1 + nd;
    if (par == 2'b01) begin f[idx] = p;  idx++; end
    if (par == 2'b10) begin f[idx] = ~p; idx++; end
    return idx + (two ? 2 : 1);
  endfunction

  task automatic set_cfg(input logic [1:0] len, input logic [1:0] par, input logic two,
                         input logic ie, input logic [7:0] n, input logic sel);
    @(negedge clk);
    char_len = len; par_mode = par; two_stop = two; irq_on_end = ie;
    div_n = n; ext_clk_sel = sel;
    P = (sel ? 64 : 16) * (int'(n) + 1);
  endtask

  task automatic do_write(input logic [8:0] d);
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic wait_start();
    while (txd !== 1'b0) @(negedge clk);
    t_fall = cyc; irq_at_fall = irq;
    @(negedge clk); irq_next = irq;
    repeat (P/2 - 1) @(negedge clk);
  endtask

  task automatic read_frame(input int nb, output logic [12:0] f);
    f = '1; f[0] = txd;
    for (int i = 1; i < nb; i++) begin
      repeat (P) @(negedge clk);
      f[i] = txd;
    end
  endtask

  task automatic wait_idle();
    repeat (P) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(buf_empty === 1'b1, "R1 buf_empty", buf_empty, 1);
    chk(irq === 1'b0, "R1 irq", irq, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_frame(input logic [8:0] d, input logic [1:0] len, input logic [1:0] par,
                         input logic two, input string req);
    logic [12:0] ef, af;
    int nb;
    set_cfg(len, par, two, 1'b0, 8'd2, 1'b0);
    nb = exp_frame(d, len, par, two, ef);
    do_write(d);
    wait_start();
    chk(irq_at_fall === 1'b1 && irq_next === 1'b0, "R10 irq at start", {irq_at_fall, irq_next}, 2);
    chk(buf_empty === 1'b1, "R8 empty after start", buf_empty, 1);
    read_frame(nb, af);
    chk(af === ef, req, af, ef);
    wait_idle();
  endtask

  task automatic t_period(input logic [7:0] n);
    int w;
    set_cfg(2'b01, 2'b00, 1'b0, 1'b0, n, 1'b0);
    do_write(9'h001);
    while (txd !== 1'b0) @(negedge clk);
    w = 0;
    while (txd === 1'b0 && w < 5000) begin w++; @(negedge clk); end
    chk(w == P, "R6 bit period", w, P);
    repeat (10*P) @(negedge clk);
  endtask

  task automatic t_ext();
    int t1, t2;
    set_cfg(2'b01, 2'b00, 1'b0, 1'b0, 8'd0, 1'b1);
    do_write(9'h001);
    while (txd !== 1'b0) @(negedge clk);
    while (txd !== 1'b1) @(negedge clk);
    t1 = cyc;
    while (txd !== 1'b0) @(negedge clk);
    t2 = cyc;
    chk(t2 - t1 == 64, "R7 external bit span", t2 - t1, 64);
    repeat (10*P) @(negedge clk);
    set_cfg(2'b01, 2'b00, 1'b0, 1'b0, 8'd2, 1'b0);
  endtask

  task automatic t_gate();
    logic [12:0] ef, af;
    int nb;
    bit stayed = 1'b1;
    set_cfg(2'b01, 2'b01, 1'b0, 1'b0, 8'd2, 1'b0);
    tx_en = 1'b0;
    do_write(9'h03C);
    chk(buf_empty === 1'b0, "R8 write fills", buf_empty, 0);
    repeat (3*P) begin @(negedge clk); if (txd !== 1'b1) stayed = 1'b0; end
    chk(stayed, "R8 no start while disabled", stayed, 1);
    chk(buf_empty === 1'b0, "R8 held while disabled", buf_empty, 0);
    tx_en = 1'b1;
    nb = exp_frame(9'h03C, 2'b01, 2'b01, 1'b0, ef);
    wait_start();
    read_frame(nb, af);
    chk(af === ef, "R8 frame after enable", af, ef);
    wait_idle();
  endtask

  task automatic t_overwrite();
    logic [12:0] ef, af;
    int nb;
    bit stayed = 1'b1;
    set_cfg(2'b01, 2'b00, 1'b0, 1'b0, 8'd2, 1'b0);
    tx_en = 1'b0;
    do_write(9'h011);
    do_write(9'h0E7);
    tx_en = 1'b1;
    nb = exp_frame(9'h0E7, 2'b01, 2'b00, 1'b0, ef);
    wait_start();
    read_frame(nb, af);
    chk(af === ef, "R13 last write sent", af, ef);
    wait_idle();
    repeat (2*P) begin @(negedge clk); if (txd !== 1'b1) stayed = 1'b0; end
    chk(stayed, "R13 single frame", stayed, 1);
  endtask

  task automatic t_b2b();
    logic [12:0] ea, eb, aa, ab;
    int na, nb;
    set_cfg(2'b01, 2'b10, 1'b1, 1'b0, 8'd2, 1'b0);
    na = exp_frame(9'h0C5, 2'b01, 2'b10, 1'b1, ea);
    nb = exp_frame(9'h03A, 2'b01, 2'b10, 1'b1, eb);
    do_write(9'h0C5);
    wait_start();
    do_write(9'h03A);
    read_frame(na, aa);
    chk(aa === ea, "R9 first frame", aa, ea);
    repeat (P) @(negedge clk);
    chk(txd === 1'b0, "R9 no gap start", txd, 0);
    read_frame(nb, ab);
    chk(ab === eb, "R9 second frame", ab, eb);
    wait_idle();
  endtask

  task automatic t_irq_end();
    logic [12:0] ef;
    int nb, lim;
    set_cfg(2'b00, 2'b01, 1'b1, 1'b1, 8'd1, 1'b0);
    nb = exp_frame(9'h055, 2'b00, 2'b01, 1'b1, ef);
    do_write(9'h055);
    wait_start();
    chk(irq_at_fall === 1'b0, "R11 no irq at start", irq_at_fall, 0);
    lim = 0;
    while (irq !== 1'b1 && lim < 5000) begin lim++; @(negedge clk); end
    chk(cyc - t_fall == nb*P, "R11 irq time", cyc - t_fall, nb*P);
    @(negedge clk);
    chk(irq === 1'b0, "R11 irq one cycle", irq, 0);
    wait_idle();
  endtask

  task automatic t_latch();
    logic [12:0] ef, af;
    int nb;
    set_cfg(2'b01, 2'b00, 1'b0, 1'b0, 8'd2, 1'b0);
    nb = exp_frame(9'h1A6, 2'b01, 2'b00, 1'b0, ef);
    do_write(9'h1A6);
    wait_start();
    char_len = 2'b10; par_mode = 2'b10; two_stop = 1'b1;
    read_frame(nb, af);
    repeat (P) @(negedge clk);
    chk(af === ef && txd === 1'b1, "R12 settings latched", af, ef);
    wait_idle();
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    tx_en = 1'b1;
    t_frame(9'h0A5, 2'b01, 2'b00, 1'b0, "R2 R3 8-bit no parity");
    t_frame(9'h1F3, 2'b00, 2'b01, 1'b0, "R3 R4 7-bit even");
    t_frame(9'h155, 2'b10, 2'b10, 1'b1, "R4 R5 9-bit odd two stop");
    t_frame(9'h1C3, 2'b11, 2'b01, 1'b1, "R3 R5 code 11 even");
    t_frame(9'h000, 2'b01, 2'b10, 1'b0, "R4 odd on zero data");
    t_frame(9'h0F0, 2'b01, 2'b11, 1'b0, "R4 code 11 no parity");
    t_period(8'd2);
    t_period(8'd5);
    t_ext();
    t_gate();
    t_overwrite();
    t_b2b();
    t_irq_end();
    t_latch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule